// File: doc/BRIEF.md
# Synchronising Serial Frame Receiver with CRC Check

This block sits behind a half-duplex serial byte interface. It takes one byte on each cycle that carries a valid strobe. In the idle state it hunts for a two-byte sync word. Once it finds one, it captures a fixed header, a 16-bit payload length, the payload and a trailing 16-bit checksum. At the end of each frame it reports whether the frame is good.

The header fields are decoded onto separate outputs:
- protocol version and frame type, split from one packed byte;
- source and destination addresses;
- a 16-bit sequence number;
- three flag bits.

Frames pass a filter only if they are addressed to the local address or to broadcast and carry the expected version. The payload of a frame that passes is streamed out with start and end markers. Because the checksum verdict arrives only after the last payload byte, downstream logic must hold delivered payload bytes until `frm_good_o` is known. Bytes from a frame that ends bad are discarded.

A frame is abandoned, and hunting resumes, in two cases. The first is a declared length above the configured maximum. The second is a silent gap inside the frame that is longer than a programmable limit.

Top module: `sync_frame_rx`

## Requirements
- R1: The receiver stays idle until it sees byte 0x4D immediately followed by byte 0x4E. A repeated 0x4D keeps it waiting for 0x4E. Any other byte in that position returns it to the idle hunt. No output event is produced while hunting.
- R2: After the sync pair the receiver takes these bytes in order:
  - version/type byte;
  - source address;
  - destination address;
  - sequence number, high byte first;
  - flags byte;
  - payload length, high byte first.

  For an accepted frame, `hdr_vld_o` pulses in the cycle after the low length byte is taken. The field outputs hold the captured values at that point.
- R3: The upper nibble of the version/type byte is presented on `ver_o` and the lower nibble on `type_o`. A frame is accepted only if the version is 0x1. `type_unknown_o` is high for type values 0x9 to 0xE and low for 0x0 to 0x8 and 0xF.
- R4: A frame is accepted only when its destination equals `local_addr_i` or equals 0xFF. A frame that is not accepted gives no `hdr_vld_o` and no payload strobes, but still ends with `frm_done_o` and `frm_good_o` low.
- R5: Flags bit 0 drives `enc_o`, bit 1 drives `cmp_o` and bit 2 drives `ack_req_o`.
- R6: A declared length greater than MAX_LEN produces a one-cycle `len_err_o` in the cycle after the low length byte, with no `hdr_vld_o`. The receiver then returns to hunting. A length equal to MAX_LEN is accepted.
- R7: For an accepted frame, each payload byte appears on `pay_byte_o` with `pay_vld_o` in the cycle after it is taken. `pay_sop_o` marks the first payload byte and `pay_eop_o` marks the last. A zero length gives no payload strobes.
- R8: The checksum is CRC-16 with polynomial 0x1021, initial value 0xFFFF, no reflection and no final XOR. It is computed over every byte from the first sync byte through the last payload byte. It is sent high byte first. `frm_done_o` pulses in the cycle after the low checksum byte. `frm_good_o` is high in that cycle only if the frame was accepted and the checksum matches.
- R9: Once the first sync byte has been taken, `idle_limit_i` consecutive clock edges without a valid byte abort the frame. `timeout_o` pulses for one cycle and hunting resumes. A limit of 0 disables the timeout.
- R10: `hdr_vld_o`, `pay_vld_o`, `frm_done_o`, `len_err_o` and `timeout_o` are single-cycle pulses, and at most one of them is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_i | input | 8 | Received byte |
| byte_vld_i | input | 1 | Strobe: byte_i is valid this cycle |
| local_addr_i | input | 8 | Own session address |
| idle_limit_i | input | IDLE_W (16) | Allowed idle edges inside a frame, 0 disables |
| hdr_vld_o | output | 1 | Header of an accepted frame is valid |
| ver_o | output | 4 | Protocol version |
| type_o | output | 4 | Frame type |
| type_unknown_o | output | 1 | Frame type is not a defined value |
| src_o | output | 8 | Source address |
| dst_o | output | 8 | Destination address |
| seq_o | output | 16 | Sequence number |
| enc_o | output | 1 | Encrypted payload flag |
| cmp_o | output | 1 | Compressed payload flag |
| ack_req_o | output | 1 | Acknowledgement requested flag |
| pay_len_o | output | LEN_W (7) | Declared payload length |
| pay_vld_o | output | 1 | Payload byte strobe |
| pay_byte_o | output | 8 | Payload byte |
| pay_sop_o | output | 1 | First payload byte |
| pay_eop_o | output | 1 | Last payload byte |
| frm_done_o | output | 1 | Frame completed |
| frm_good_o | output | 1 | Frame accepted with matching CRC |
| len_err_o | output | 1 | Frame aborted on oversize length |
| timeout_o | output | 1 | Frame aborted on idle gap |

## Verification
A wrong state register shows up within one byte time. The stream is then read at the wrong byte position, so the header pulse, the payload markers or the done pulse appear one or more cycles away from where the byte count places them. A corrupted CRC register or a wrong byte selection for the checksum first shows at the end of the frame, as a wrong `frm_good_o`. A faulty idle counter shows as a `timeout_o` on the wrong edge. The bench model advances with every clock and compares every event output on every cycle, so each of these faults is caught in the cycle it first reaches the ports.

// File: rtl/frx_pkg.sv
package frx_pkg;

  typedef enum logic [3:0] {
    ST_HUNT, ST_SYNC, ST_VT, ST_SRC, ST_DST, ST_SEQH, ST_SEQL, ST_FLG,
    ST_LENH, ST_LENL, ST_PAY, ST_CRCH, ST_CRCL
  } rx_state_e;

  localparam logic [7:0]  SYNC_A    = 8'h4D;
  localparam logic [7:0]  SYNC_B    = 8'h4E;
  localparam logic [7:0]  ADDR_BC   = 8'hFF;
  localparam logic [3:0]  PROTO_VER = 4'h1;
  localparam logic [15:0] CRC_POLY  = 16'h1021;
  localparam logic [15:0] CRC_SEED  = 16'hFFFF;

  function automatic logic [15:0] crc_step(logic [15:0] c, logic [7:0] b);
    logic [15:0] r;
    r = c ^ {b, 8'h00};
    for (int i = 0; i < 8; i++) begin
      r = r[15] ? ((r << 1) ^ CRC_POLY) : (r << 1);
    end
    return r;
  endfunction

endpackage

// File: rtl/frx_crc16.sv
module frx_crc16
  import frx_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        seed_i,
  input  logic        upd_i,
  input  logic [7:0]  byte_i,
  output logic [15:0] crc_o
);
  logic [15:0] crc_q;

  // seed_i restarts the sum and absorbs the current byte in one step
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_q <= CRC_SEED;
    else if (seed_i) crc_q <= crc_step(CRC_SEED, byte_i);
    else if (upd_i)  crc_q <= crc_step(crc_q, byte_i);
  end

  assign crc_o = crc_q;
endmodule

// File: rtl/frx_idle_timer.sv
module frx_idle_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             kick_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_inc;

  assign cnt_inc  = cnt_q + 1'b1;
  assign expire_o = run_i && !kick_i && (limit_i != '0) && (cnt_inc == limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || kick_i)  cnt_q <= '0;
    else                        cnt_q <= cnt_inc;
  end
endmodule

// File: rtl/sync_frame_rx.sv
module sync_frame_rx
  import frx_pkg::*;
#(
  parameter int unsigned MAX_LEN = 64,
  parameter int unsigned IDLE_W  = 16,
  localparam int unsigned LEN_W  = $clog2(MAX_LEN + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        byte_i,
  input  logic              byte_vld_i,
  input  logic [7:0]        local_addr_i,
  input  logic [IDLE_W-1:0] idle_limit_i,
  output logic              hdr_vld_o,
  output logic [3:0]        ver_o,
  output logic [3:0]        type_o,
  output logic              type_unknown_o,
  output logic [7:0]        src_o,
  output logic [7:0]        dst_o,
  output logic [15:0]       seq_o,
  output logic              enc_o,
  output logic              cmp_o,
  output logic              ack_req_o,
  output logic [LEN_W-1:0]  pay_len_o,
  output logic              pay_vld_o,
  output logic [7:0]        pay_byte_o,
  output logic              pay_sop_o,
  output logic              pay_eop_o,
  output logic              frm_done_o,
  output logic              frm_good_o,
  output logic              len_err_o,
  output logic              timeout_o
);
  localparam logic [15:0] LEN_CAP = 16'(MAX_LEN);

  rx_state_e        state_q;
  logic [7:0]       vt_q, src_q, dst_q, len_hi_q, crc_hi_q;
  logic [15:0]      seq_q;
  logic [2:0]       flg_q;
  logic [LEN_W-1:0] len_q, cnt_q;
  logic             acc_q;
  logic             hdr_q, pv_q, sop_q, eop_q, done_q, good_q, lerr_q, to_q;
  logic [7:0]       pb_q;

  logic        expire, accept, crc_seed, crc_upd;
  logic [15:0] crc_run, len_full;

  assign len_full = {len_hi_q, byte_i};
  assign accept   = ((dst_q == local_addr_i) || (dst_q == ADDR_BC)) && (vt_q[7:4] == PROTO_VER);

  assign crc_seed = byte_vld_i && (byte_i == SYNC_A) && (state_q inside {ST_HUNT, ST_SYNC});
  assign crc_upd  = byte_vld_i &&
                    ((state_q == ST_SYNC && byte_i == SYNC_B) ||
                     (state_q inside {ST_VT, ST_SRC, ST_DST, ST_SEQH, ST_SEQL,
                                      ST_FLG, ST_LENH, ST_LENL, ST_PAY}));

  frx_crc16 u_crc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .seed_i (crc_seed),
    .upd_i  (crc_upd),
    .byte_i (byte_i),
    .crc_o  (crc_run)
  );

  frx_idle_timer #(.CNT_W(IDLE_W)) u_idle (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (state_q != ST_HUNT),
    .kick_i   (byte_vld_i),
    .limit_i  (idle_limit_i),
    .expire_o (expire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_HUNT;
      vt_q     <= '0;
      src_q    <= '0;
      dst_q    <= '0;
      seq_q    <= '0;
      flg_q    <= '0;
      len_hi_q <= '0;
      len_q    <= '0;
      cnt_q    <= '0;
      crc_hi_q <= '0;
      acc_q    <= 1'b0;
      hdr_q    <= 1'b0;
      pv_q     <= 1'b0;
      pb_q     <= '0;
      sop_q    <= 1'b0;
      eop_q    <= 1'b0;
      done_q   <= 1'b0;
      good_q   <= 1'b0;
      lerr_q   <= 1'b0;
      to_q     <= 1'b0;
    end else begin
      hdr_q  <= 1'b0;
      pv_q   <= 1'b0;
      sop_q  <= 1'b0;
      eop_q  <= 1'b0;
      done_q <= 1'b0;
      good_q <= 1'b0;
      lerr_q <= 1'b0;
      to_q   <= 1'b0;
      if (expire) begin
        state_q <= ST_HUNT;
        to_q    <= 1'b1;
      end else if (byte_vld_i) begin
        unique case (state_q)
          ST_HUNT: if (byte_i == SYNC_A) state_q <= ST_SYNC;
          ST_SYNC: begin
            if (byte_i == SYNC_B)      state_q <= ST_VT;
            else if (byte_i != SYNC_A) state_q <= ST_HUNT;
          end
          ST_VT:   begin vt_q  <= byte_i;        state_q <= ST_SRC;  end
          ST_SRC:  begin src_q <= byte_i;        state_q <= ST_DST;  end
          ST_DST:  begin dst_q <= byte_i;        state_q <= ST_SEQH; end
          ST_SEQH: begin seq_q[15:8] <= byte_i;  state_q <= ST_SEQL; end
          ST_SEQL: begin seq_q[7:0]  <= byte_i;  state_q <= ST_FLG;  end
          ST_FLG:  begin flg_q <= byte_i[2:0];   state_q <= ST_LENH; end
          ST_LENH: begin len_hi_q <= byte_i;     state_q <= ST_LENL; end
          ST_LENL: begin
            if (len_full > LEN_CAP) begin
              lerr_q  <= 1'b1;
              state_q <= ST_HUNT;
            end else begin
              len_q   <= LEN_W'(len_full);
              acc_q   <= accept;
              hdr_q   <= accept;
              cnt_q   <= '0;
              state_q <= (len_full == 16'd0) ? ST_CRCH : ST_PAY;
            end
          end
          ST_PAY: begin
            pv_q  <= acc_q;
            pb_q  <= byte_i;
            sop_q <= acc_q && (cnt_q == '0);
            eop_q <= acc_q && (cnt_q == len_q - 1'b1);
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == len_q - 1'b1) state_q <= ST_CRCH;
          end
          ST_CRCH: begin crc_hi_q <= byte_i; state_q <= ST_CRCL; end
          ST_CRCL: begin
            done_q  <= 1'b1;
            good_q  <= acc_q && ({crc_hi_q, byte_i} == crc_run);
            state_q <= ST_HUNT;
          end
          default: state_q <= ST_HUNT;
        endcase
      end
    end
  end

  assign hdr_vld_o      = hdr_q;
  assign ver_o          = vt_q[7:4];
  assign type_o         = vt_q[3:0];
  assign type_unknown_o = (vt_q[3:0] > 4'h8) && (vt_q[3:0] != 4'hF);
  assign src_o          = src_q;
  assign dst_o          = dst_q;
  assign seq_o          = seq_q;
  assign enc_o          = flg_q[0];
  assign cmp_o          = flg_q[1];
  assign ack_req_o      = flg_q[2];
  assign pay_len_o      = len_q;
  assign pay_vld_o      = pv_q;
  assign pay_byte_o     = pb_q;
  assign pay_sop_o      = sop_q;
  assign pay_eop_o      = eop_q;
  assign frm_done_o     = done_q;
  assign frm_good_o     = good_q;
  assign len_err_o      = lerr_q;
  assign timeout_o      = to_q;
endmodule

// File: rtl/frx_checker.sv
module frx_checker #(
  parameter int unsigned MAX_LEN = 64,
  localparam int unsigned LEN_W  = $clog2(MAX_LEN + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             byte_vld_i,
  input logic [7:0]       local_addr_i,
  input logic             hdr_vld_o,
  input logic [3:0]       ver_o,
  input logic [7:0]       dst_o,
  input logic [LEN_W-1:0] pay_len_o,
  input logic             pay_vld_o,
  input logic             pay_sop_o,
  input logic             pay_eop_o,
  input logic             frm_done_o,
  input logic             frm_good_o,
  input logic             len_err_o,
  input logic             timeout_o
);
  assert_one_event_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({hdr_vld_o, pay_vld_o, frm_done_o, len_err_o, timeout_o}));

  assert_hdr_after_byte_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_vld_o |-> $past(byte_vld_i));

  assert_hdr_version_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_vld_o |-> (ver_o == 4'h1));

  assert_hdr_addr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_vld_o |-> (dst_o == local_addr_i || dst_o == 8'hFF));

  assert_len_cap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_vld_o |-> (pay_len_o <= LEN_W'(MAX_LEN)));

  assert_marks_in_beat_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pay_sop_o || pay_eop_o) |-> pay_vld_o);

  assert_pay_after_byte_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pay_vld_o |-> $past(byte_vld_i));

  assert_good_in_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_good_o |-> frm_done_o);

  assert_done_after_byte_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_done_o |-> $past(byte_vld_i));

  assert_idle_abort_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> !$past(byte_vld_i));
endmodule

bind sync_frame_rx frx_checker #(.MAX_LEN(MAX_LEN)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .byte_vld_i   (byte_vld_i),
  .local_addr_i (local_addr_i),
  .hdr_vld_o    (hdr_vld_o),
  .ver_o        (ver_o),
  .dst_o        (dst_o),
  .pay_len_o    (pay_len_o),
  .pay_vld_o    (pay_vld_o),
  .pay_sop_o    (pay_sop_o),
  .pay_eop_o    (pay_eop_o),
  .frm_done_o   (frm_done_o),
  .frm_good_o   (frm_good_o),
  .len_err_o    (len_err_o),
  .timeout_o    (timeout_o)
);

// File: tb/sim_sync_frame_rx.sv
module sim_sync_frame_rx;
  localparam int MAX_LEN = 64;
  localparam int LEN_W   = $clog2(MAX_LEN + 1);
  localparam int LIMIT   = 20;
  localparam logic [7:0] ME = 8'h21;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0]  byte_in = '0;
  logic        vld_in = 1'b0;
  logic [15:0] limit_in = 16'(LIMIT);

  logic hdr_vld, type_unk, enc, cmp, ackr, pv, sop, eop, done, good, lerr, tmo;
  logic [3:0] ver, typ;
  logic [7:0] src, dst, pb;
  logic [15:0] seq;
  logic [LEN_W-1:0] plen;

  always #5 clk = ~clk;

  sync_frame_rx #(.MAX_LEN(MAX_LEN), .IDLE_W(16)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .byte_i(byte_in), .byte_vld_i(vld_in),
    .local_addr_i(ME), .idle_limit_i(limit_in),
    .hdr_vld_o(hdr_vld), .ver_o(ver), .type_o(typ), .type_unknown_o(type_unk),
    .src_o(src), .dst_o(dst), .seq_o(seq), .enc_o(enc), .cmp_o(cmp),
    .ack_req_o(ackr), .pay_len_o(plen), .pay_vld_o(pv), .pay_byte_o(pb),
    .pay_sop_o(sop), .pay_eop_o(eop), .frm_done_o(done), .frm_good_o(good),
    .len_err_o(lerr), .timeout_o(tmo)
  );

  int n_chk = 0, n_err = 0;
  int cnt_good = 0, cnt_bad = 0, cnt_lerr = 0, cnt_to = 0, cnt_hdr = 0, cnt_pay = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] ref_crc(input logic [7:0] q[$]);
    logic [15:0] c = 16'hFFFF;
    foreach (q[k]) begin
      for (int b = 7; b >= 0; b--) begin
        logic fb;
        fb = c[15] ^ q[k][b];
        c  = {c[14:0], 1'b0};
        if (fb) c = c ^ 16'h1021;
      end
    end
    return c;
  endfunction

  // behavioural reference: phase 0 hunt, 1 saw first sync, 2 header, 3 payload, 4 crc hi, 5 crc lo
  int phase = 0, idle = 0, plen_m = 0, pidx = 0;
  bit acc_m = 0;
  logic [7:0] fr[$];
  logic [7:0] crc_hi_m;
  bit e_hdr, e_pv, e_sop, e_eop, e_done, e_good, e_lerr, e_to;
  logic [7:0] e_pb;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase = 0; idle = 0;
      {e_hdr, e_pv, e_sop, e_eop, e_done, e_good, e_lerr, e_to} = '0;
    end else begin
      {e_hdr, e_pv, e_sop, e_eop, e_done, e_good, e_lerr, e_to} = '0;
      if (!vld_in) begin
        if (phase != 0 && limit_in != 0) begin
          idle++;
          if (idle == int'(limit_in)) begin e_to = 1; phase = 0; end
        end
      end else begin
        idle = 0;
        case (phase)
          0: if (byte_in == 8'h4D) begin phase = 1; fr = {byte_in}; end
          1: if (byte_in == 8'h4E) begin phase = 2; fr.push_back(byte_in); end
             else if (byte_in == 8'h4D) fr = {byte_in};
             else phase = 0;
          2: begin
            fr.push_back(byte_in);
            if (fr.size() == 10) begin
              plen_m = fr[8] * 256 + fr[9];
              if (plen_m > MAX_LEN) begin e_lerr = 1; phase = 0; end
              else begin
                acc_m = (fr[4] == ME || fr[4] == 8'hFF) && (fr[2][7:4] == 4'h1);
                e_hdr = acc_m; pidx = 0;
                phase = (plen_m == 0) ? 4 : 3;
              end
            end
          end
          3: begin
            fr.push_back(byte_in);
            if (acc_m) begin
              e_pv = 1; e_pb = byte_in;
              e_sop = (pidx == 0); e_eop = (pidx == plen_m - 1);
            end
            pidx++;
            if (pidx == plen_m) phase = 4;
          end
          4: begin crc_hi_m = byte_in; phase = 5; end
          default: begin
            e_done = 1;
            e_good = acc_m && ({crc_hi_m, byte_in} == ref_crc(fr));
            phase = 0;
          end
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(hdr_vld == e_hdr, "R2 hdr_vld", hdr_vld, e_hdr);
      chk(lerr == e_lerr,   "R6 len_err", lerr, e_lerr);
      chk(pv == e_pv,       "R7 pay_vld", pv, e_pv);
      chk(done == e_done,   "R8 frm_done", done, e_done);
      chk(tmo == e_to,      "R9 timeout", tmo, e_to);
      chk($countones({hdr_vld, pv, done, lerr, tmo}) <= 1, "R10 exclusive events",
          $countones({hdr_vld, pv, done, lerr, tmo}), 1);
      if (e_pv) begin
        chk(pb == e_pb,   "R7 pay_byte", pb, e_pb);
        chk(sop == e_sop, "R7 sop", sop, e_sop);
        chk(eop == e_eop, "R7 eop", eop, e_eop);
      end
      if (e_done) chk(good == e_good, "R8 frm_good", good, e_good);
      if (e_hdr) begin
        chk(ver == fr[2][7:4], "R3 version", ver, fr[2][7:4]);
        chk(typ == fr[2][3:0], "R3 type", typ, fr[2][3:0]);
        chk(type_unk == (fr[2][3:0] inside {[4'h9:4'hE]}), "R3 unknown type", type_unk,
            fr[2][3:0] inside {[4'h9:4'hE]});
        chk(src == fr[3], "R2 src", src, fr[3]);
        chk(dst == fr[4], "R4 dst", dst, fr[4]);
        chk(seq == {fr[5], fr[6]}, "R2 seq", seq, {fr[5], fr[6]});
        chk({ackr, cmp, enc} == fr[7][2:0], "R5 flags", {ackr, cmp, enc}, fr[7][2:0]);
        chk(int'(plen) == plen_m, "R2 length", plen, plen_m);
      end
      if (hdr_vld) cnt_hdr++;
      if (pv) cnt_pay++;
      if (done && good) cnt_good++;
      if (done && !good) cnt_bad++;
      if (lerr) cnt_lerr++;
      if (tmo) cnt_to++;
    end
  end

  task automatic put(input logic [7:0] b, input int gap);
    vld_in = 1'b1; byte_in = b;
    @(negedge clk);
    if (gap > 0) begin
      vld_in = 1'b0;
      repeat (gap) @(negedge clk);
    end
  endtask

  task automatic quiet(input int n);
    vld_in = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic frame(input logic [7:0] vt, input logic [7:0] s, input logic [7:0] d,
                       input logic [15:0] sq, input logic [7:0] fl, input int len,
                       input bit bad_crc, input int gap);
    logic [7:0] q[$];
    logic [15:0] c;
    q = {8'h4D, 8'h4E, vt, s, d, sq[15:8], sq[7:0], fl, 8'(len >> 8), 8'(len)};
    for (int i = 0; i < len; i++) q.push_back(8'(i * 37 + sq));
    c = ref_crc(q);
    q.push_back(c[15:8]);
    q.push_back(bad_crc ? ~c[7:0] : c[7:0]);
    foreach (q[k]) put(q[k], gap);
    quiet(3);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL R10 watchdog act=hung exp=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({hdr_vld, pv, done, good, lerr, tmo} == 6'b0, "R10 reset state",
        {hdr_vld, pv, done, good, lerr, tmo}, 0);
    rst_n = 1'b1;
    quiet(2);
    // R1: noise and a false start before the sync pair
    put(8'h12, 0); put(8'h4E, 0); put(8'h4D, 0); put(8'h33, 1);
    chk(cnt_hdr == 0 && cnt_to == 0, "R1 noise ignored", cnt_hdr, 0);
    frame(8'h16, 8'h05, ME, 16'h1234, 8'h05, 3, 0, 0);        // R5 enc+ack
    frame(8'h19, 8'h07, 8'hFF, 16'hBEEF, 8'h02, 0, 0, 1);     // R3 unknown, R7 len 0
    frame(8'h16, 8'h05, 8'h33, 16'h0001, 8'h00, 4, 0, 0);     // R4 other address
    frame(8'h26, 8'h05, ME, 16'h0002, 8'h00, 2, 0, 0);        // R3 bad version
    frame(8'h1F, 8'h09, ME, 16'h0003, 8'h07, 5, 1, 0);        // R8 bad crc
    frame(8'h16, 8'h01, ME, 16'h0004, 8'h00, MAX_LEN + 1, 0, 0); // R6 oversize
    quiet(MAX_LEN + 8);
    put(8'h4D, 0); put(8'h4D, 0);                              // R1 repeated sync byte
    frame(8'h18, 8'h02, ME, 16'hA5A5, 8'h04, 2, 0, 0);
    put(8'h4D, 0); put(8'h4E, 0); put(8'h16, 0);               // R9 abandoned header
    quiet(LIMIT + 5);
    frame(8'h14, 8'h03, 8'hFF, 16'h0F0F, 8'h01, 1, 0, LIMIT - 1); // R9 gap just under limit
    frame(8'h10, 8'h04, ME, 16'h7777, 8'h00, MAX_LEN, 0, 0);  // R6 length at cap
    quiet(5);
    chk(cnt_good == 5, "R8 good frames", cnt_good, 5);
    chk(cnt_bad == 3,  "R4 rejected frames", cnt_bad, 3);
    chk(cnt_lerr == 1, "R6 oversize aborts", cnt_lerr, 1);
    chk(cnt_to == 1,   "R9 timeouts", cnt_to, 1);
    chk(cnt_hdr == 6,  "R2 headers", cnt_hdr, 6);
    chk(cnt_pay == 3 + 5 + 2 + 1 + MAX_LEN, "R7 payload beats", cnt_pay, 11 + MAX_LEN);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule